// File: doc/BRIEF.md
# Read-Only Tag Identification Frame Serialiser

This block builds the 64-bit identification frame that a read-only low-frequency tag repeats back to a reader. It takes a 40-bit identifier from a port and a variant select. It adds a run of nine ones as the preamble, an even or odd parity bit after each 4-bit row, four column parity bits and a closing zero. It then hands the frame out one bit at a time to a downstream line encoder. An external carrier-cycle divider supplies a single-cycle `bit_tick` once per bit period. Each tick moves the frame on by one bit.

The frame runs in a loop for as long as reset is released. The last bit is followed at once by the first preamble bit, with no idle slot between them. The identifier and the variant select are copied into shadow registers on the tick that presents the first preamble bit. The whole frame in flight comes from one consistent snapshot.

A sequencer with five named states sets the bit order:
- `ST_HEADER` counts the preamble bits. Transition *preamble done* leads to `ST_ROW_DATA`.
- `ST_ROW_DATA` counts four data bits. Transition *row filled* leads to `ST_ROW_PAR`.
- `ST_ROW_PAR` has two transitions. *next row* goes back to `ST_ROW_DATA`. *last row* goes on to `ST_COL_PAR`.
- `ST_COL_PAR` counts four column bits. Transition *columns done* leads to `ST_STOP`.
- `ST_STOP` takes transition *wrap* back to `ST_HEADER`.

Every transition happens only on a tick.

Top module: `tag_frame_gen`

## Requirements
- R1: While `rst_n` is low, `frame_bit` and `frame_start` are 0. The first `bit_tick` after reset is released presents frame position 0, which is a preamble bit of value 1, with `frame_start` high.
- R2: A frame is 64 bits, sent in this order: 9 preamble bits of value 1, then rows 0 to 9, then 4 column parity bits, then 1 stop bit. Each row is 4 data bits followed by that row's parity bit. Data bit c of row r (c = 0 is sent first) is `id_in[39 - (4*r + c)]`, so `id_in[39]` is the first data bit on the line.
- R3: With `psk_mode` = 0, every row parity bit makes the XOR of its 4 data bits and itself equal to 0 (even parity).
- R4: With `psk_mode` = 1, the parity bits of rows 0 and 1 are odd: the XOR of the row and its parity bit is 1. The parity bits of rows 2 to 9 stay even.
- R5: Column parity bit c is the XOR of data bit c over all 10 rows (even parity), including rows 0 and 1, in both variants.
- R6: The stop bit, frame position 63, is always 0.
- R7: After position 63 the next tick presents position 0 again. `frame_start` is high only after the tick that presents position 0, so it pulses once every 64 ticks.
- R8: `frame_bit` changes only on a clock edge where `bit_tick` is high. `frame_start` is a single-cycle pulse that follows such an edge.
- R9: `id_in` and `psk_mode` are sampled only on the tick that presents position 0. A change at any other time has no effect on the frame in flight and shows up in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, restarts the frame at position 0 |
| bit_tick | input | 1 | Single-cycle strobe that advances the frame by one bit |
| psk_mode | input | 1 | Variant select: 0 = all row parities even, 1 = rows 0 and 1 odd |
| id_in | input | 40 | Identifier, sampled at frame start |
| frame_bit | output | 1 | Current frame bit for the line encoder |
| frame_start | output | 1 | One-cycle pulse when frame position 0 is presented |

## Verification
A sequencer that loses its place in the row or column counts shows up at the ports within one frame. The wrong bit lands in a parity or stop slot, and the next `frame_start` comes at a distance other than 64 ticks. A corrupt shadow register or parity term shows up at the first data or parity bit that depends on it. The bench compares every one of the 64 positions against its own model, so such a fault is caught no later than the next frame. A capture that happens at the wrong moment is exposed by changing the identifier and the variant in the middle of a frame, then checking both the rest of that frame and the frame after it.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

    // Sequencer states, one per kind of frame slot
    typedef enum logic [2:0] {
        ST_HEADER   = 3'd0,
        ST_ROW_DATA = 3'd1,
        ST_ROW_PAR  = 3'd2,
        ST_COL_PAR  = 3'd3,
        ST_STOP     = 3'd4
    } tfg_state_e;

endpackage

// File: rtl/tfg_parity.sv
// Splits the captured identifier into rows and derives row and column parity.
module tfg_parity #(
    parameter int ROWS     = 10,
    parameter int COLS     = 4,
    parameter int ODD_ROWS = 2
) (
    input  logic [ROWS*COLS-1:0]       id_i,
    input  logic                       odd_lead_i,
    output logic [ROWS-1:0][COLS-1:0]  rows_o,
    output logic [ROWS-1:0]            row_par_o,
    output logic [COLS-1:0]            col_par_o
);
    localparam int ID_W = ROWS * COLS;

    // Row r, column c maps to id bit ID_W-1-(r*COLS+c)
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign rows_o[r][c] = id_i[ID_W-1-(r*COLS+c)];
        end
        if (r < ODD_ROWS) begin : g_odd
            assign row_par_o[r] = (^rows_o[r]) ^ odd_lead_i;
        end else begin : g_even
            assign row_par_o[r] = ^rows_o[r];
        end
    end

    always_comb begin
        col_par_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            col_par_o = col_par_o ^ rows_o[r];
        end
    end

endmodule

// File: rtl/tfg_seq.sv
// Slot sequencer: walks preamble, rows, column parity and stop slot.
module tfg_seq
    import tfg_pkg::*;
#(
    parameter int HDR_LEN = 9,
    parameter int ROWS    = 10,
    parameter int COLS    = 4,
    localparam int MAXC   = (HDR_LEN > COLS) ? HDR_LEN : COLS,
    localparam int CNT_W  = $clog2(MAXC),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output tfg_state_e        state_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              start_slot_o
);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);

    tfg_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ROW_W-1:0]  row_q, row_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            row_q   <= row_n;
        end
    end

    // Next-state logic; every move waits for a tick
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        row_n   = row_q;
        if (tick_i) begin
            unique case (state_q)
                ST_HEADER: begin
                    if (cnt_q == HDR_LAST) begin      // preamble done
                        state_n = ST_ROW_DATA;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_ROW_DATA: begin
                    if (cnt_q == COL_LAST) begin      // row filled
                        state_n = ST_ROW_PAR;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_ROW_PAR: begin
                    if (row_q == ROW_LAST) begin      // last row
                        state_n = ST_COL_PAR;
                        row_n   = '0;
                    end else begin                    // next row
                        state_n = ST_ROW_DATA;
                        row_n   = row_q + ROW_ONE;
                    end
                end
                ST_COL_PAR: begin
                    if (cnt_q == COL_LAST) begin      // columns done
                        state_n = ST_STOP;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_STOP: begin                        // wrap
                    state_n = ST_HEADER;
                    cnt_n   = '0;
                    row_n   = '0;
                end
                default: begin
                    state_n = ST_HEADER;
                    cnt_n   = '0;
                    row_n   = '0;
                end
            endcase
        end
    end

    assign state_o      = state_q;
    assign cnt_o        = cnt_q;
    assign row_o        = row_q;
    assign start_slot_o = (state_q == ST_HEADER) && (cnt_q == '0);

endmodule

// File: rtl/tfg_bit_sel.sv
// Picks the frame bit that belongs to the current slot.
module tfg_bit_sel
    import tfg_pkg::*;
#(
    parameter int ROWS  = 10,
    parameter int COLS  = 4,
    parameter int CNT_W = 4,
    parameter int ROW_W = 4,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  tfg_state_e                 state_i,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [ROW_W-1:0]           row_i,
    input  logic [ROWS-1:0][COLS-1:0]  rows_i,
    input  logic [ROWS-1:0]            row_par_i,
    input  logic [COLS-1:0]            col_par_i,
    output logic                       bit_o
);
    logic [COL_W-1:0] col;
    assign col = cnt_i[COL_W-1:0];

    always_comb begin
        unique case (state_i)
            ST_HEADER:   bit_o = 1'b1;
            ST_ROW_DATA: bit_o = rows_i[row_i][col];
            ST_ROW_PAR:  bit_o = row_par_i[row_i];
            ST_COL_PAR:  bit_o = col_par_i[col];
            ST_STOP:     bit_o = 1'b0;
            default:     bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tag_frame_gen.sv
// Serialises the repeating 64-bit read-only tag identification frame.
module tag_frame_gen
    import tfg_pkg::*;
#(
    parameter int HDR_LEN  = 9,
    parameter int ROWS     = 10,
    parameter int COLS     = 4,
    parameter int ODD_ROWS = 2,
    localparam int ID_W    = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             psk_mode,
    input  logic [ID_W-1:0]  id_in,
    output logic             frame_bit,
    output logic             frame_start
);
    localparam int MAXC  = (HDR_LEN > COLS) ? HDR_LEN : COLS;
    localparam int CNT_W = $clog2(MAXC);
    localparam int ROW_W = $clog2(ROWS);

    tfg_state_e                state;
    logic [CNT_W-1:0]          cnt;
    logic [ROW_W-1:0]          row;
    logic                      start_slot;
    logic [ID_W-1:0]           id_sh;
    logic                      psk_sh;
    logic [ROWS-1:0][COLS-1:0] rows;
    logic [ROWS-1:0]           row_par;
    logic [COLS-1:0]           col_par;
    logic                      slot_bit;

    tfg_seq #(
        .HDR_LEN (HDR_LEN),
        .ROWS    (ROWS),
        .COLS    (COLS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (bit_tick),
        .state_o      (state),
        .cnt_o        (cnt),
        .row_o        (row),
        .start_slot_o (start_slot)
    );

    // Snapshot of identifier and variant, taken as position 0 goes out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_sh  <= '0;
            psk_sh <= 1'b0;
        end else if (bit_tick && start_slot) begin
            id_sh  <= id_in;
            psk_sh <= psk_mode;
        end
    end

    tfg_parity #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .ODD_ROWS (ODD_ROWS)
    ) u_par (
        .id_i       (id_sh),
        .odd_lead_i (psk_sh),
        .rows_o     (rows),
        .row_par_o  (row_par),
        .col_par_o  (col_par)
    );

    tfg_bit_sel #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .CNT_W (CNT_W),
        .ROW_W (ROW_W)
    ) u_sel (
        .state_i   (state),
        .cnt_i     (cnt),
        .row_i     (row),
        .rows_i    (rows),
        .row_par_i (row_par),
        .col_par_i (col_par),
        .bit_o     (slot_bit)
    );

    // Output register: updated only on a tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_bit   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= bit_tick && start_slot;
            if (bit_tick) begin
                frame_bit <= slot_bit;
            end
        end
    end

endmodule

// File: rtl/tfg_chk.sv
// Port-level checker bound to tag_frame_gen.
module tfg_chk #(
    parameter int FRAME_LEN = 64
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic frame_bit,
    input logic frame_start
);
    localparam int PW = $clog2(FRAME_LEN + 1);
    localparam logic [PW-1:0] POS_LAST = PW'(FRAME_LEN - 1);
    localparam logic [PW-1:0] POS_ONE  = PW'(1);

    // Ticks seen since reset, modulo the frame length
    logic [PW-1:0] pos_chk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_chk <= '0;
        end else if (bit_tick) begin
            pos_chk <= (pos_chk == POS_LAST) ? '0 : pos_chk + POS_ONE;
        end
    end

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(frame_bit));

    // R8
    start_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !frame_start);

    // R7
    start_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pos_chk == POS_ONE));

    // R7
    start_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_tick) && (pos_chk == POS_ONE)) |-> frame_start);

    // R2
    start_is_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> frame_bit);

    // R6
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_tick) && (pos_chk == '0)) |-> !frame_bit);

endmodule

bind tag_frame_gen tfg_chk #(
    .FRAME_LEN (HDR_LEN + ROWS * (COLS + 1) + COLS + 1)
) u_tfg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .frame_bit   (frame_bit),
    .frame_start (frame_start)
);

// File: tb/tb_tag_frame_gen.sv
module tb_tag_frame_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        psk_mode = 1'b0;
    logic [39:0] id_in = '0;
    logic        frame_bit;
    logic        frame_start;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tag_frame_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .psk_mode    (psk_mode),
        .id_in       (id_in),
        .frame_bit   (frame_bit),
        .frame_start (frame_start)
    );

    typedef struct packed {
        logic        psk;
        logic [39:0] id;
    } vec_t;

    // Stimulus table; expected frames come from frame_model below
    localparam vec_t VECS [8] = '{
        '{1'b0, 40'h00_0000_0000},
        '{1'b0, 40'hFF_FFFF_FFFF},
        '{1'b1, 40'hFF_FFFF_FFFF},
        '{1'b0, 40'h01_2345_6789},
        '{1'b1, 40'hA5_A5A5_A5A5},
        '{1'b1, 40'hFF_FF00_0000},
        '{1'b0, 40'h80_0000_0001},
        '{1'b1, 40'h00_0000_00FF}
    };

    // Bit k of the result is the k-th bit on the line
    function automatic logic [63:0] frame_model(input logic [39:0] id, input logic p);
        logic [63:0] f;
        logic [5:0]  k;
        logic        par;
        logic        d;
        f = '0;
        k = '0;
        for (int h = 0; h < 9; h++) begin
            f[k] = 1'b1;
            k = k + 6'd1;
        end
        for (int r = 0; r < 10; r++) begin
            par = p && (r < 2);
            for (int c = 0; c < 4; c++) begin
                d = id[6'(39 - 4*r - c)];
                f[k] = d;
                par = par ^ d;
                k = k + 6'd1;
            end
            f[k] = par;
            k = k + 6'd1;
        end
        for (int c = 0; c < 4; c++) begin
            par = 1'b0;
            for (int r = 0; r < 10; r++) par = par ^ id[6'(39 - 4*r - c)];
            f[k] = par;
            k = k + 6'd1;
        end
        f[k] = 1'b0;
        return f;
    endfunction

    function automatic string tag_of(input int pos, input logic p);
        int rel;
        if (pos < 9) return "R2";
        if (pos < 59) begin
            rel = pos - 9;
            if (rel % 5 == 4) return p ? "R4" : "R3";
            return "R2";
        end
        if (pos < 63) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
        end
    endtask

    // One tick, sample after the edge, then one idle cycle to confirm hold
    task automatic step(output logic b, output logic s);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        b = frame_bit;
        s = frame_start;
        @(negedge clk);
        check("R8", "bit held without tick", frame_bit, b);
        check("R8", "start is one cycle", frame_start, 1'b0);
    endtask

    task automatic run_bits(input logic [63:0] expf, input logic p, input int from, input int upto);
        logic b, s;
        for (int pos = from; pos <= upto; pos++) begin
            step(b, s);
            check(tag_of(pos, p), $sformatf("frame bit %0d", pos), b, expf[pos]);
            check("R7", $sformatf("frame_start at pos %0d", pos), s, pos == 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] fa, fb;
        logic b, s;

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "frame_bit in reset", frame_bit, 1'b0);
        check("R1", "frame_start in reset", frame_start, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "frame_bit idle after reset", frame_bit, 1'b0);
        check("R1", "frame_start idle after reset", frame_start, 1'b0);

        // Table walk: frames back to back, so each start also checks the wrap (R7)
        for (int v = 0; v < 8; v++) begin
            id_in    = VECS[v].id;
            psk_mode = VECS[v].psk;
            run_bits(frame_model(VECS[v].id, VECS[v].psk), VECS[v].psk, 0, 63);
        end

        // R9: change inputs mid-frame; this frame keeps the old snapshot
        id_in    = 40'h3C_96E1_0F5A;
        psk_mode = 1'b0;
        fa = frame_model(40'h3C_96E1_0F5A, 1'b0);
        run_bits(fa, 1'b0, 0, 19);
        id_in    = 40'hC3_691E_F0A5;
        psk_mode = 1'b1;
        fb = frame_model(40'hC3_691E_F0A5, 1'b1);
        for (int pos = 20; pos <= 63; pos++) begin
            step(b, s);
            check("R9", $sformatf("old frame bit %0d after input change", pos), b, fa[pos]);
        end
        run_bits(fb, 1'b1, 0, 63);

        // R1: reset in mid-frame restarts at position 0
        run_bits(fb, 1'b1, 0, 29);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1", "frame_bit after mid-frame reset", frame_bit, 1'b0);
        check("R1", "frame_start after mid-frame reset", frame_start, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        id_in    = 40'h12_3456_789A;
        psk_mode = 1'b0;
        step(b, s);
        check("R1", "first bit after reset release", b, 1'b1);
        check("R1", "first start after reset release", s, 1'b1);
        run_bits(frame_model(40'h12_3456_789A, 1'b0), 1'b0, 1, 63);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule